// File: doc/BRIEF.md
# USB Device Bus-Event Interrupt Unit

This unit sits beside a full-speed USB device controller and turns bus-level events into interrupt flags that a CPU can read and clear. It watches decoded line-state indications (idle J, non-idle activity, end of a bus reset) and a start-of-frame strobe from the packet decoder. From these it raises four sticky flags: suspend detected, wake-up while suspended, end of bus reset, and start of frame. A registered interrupt line is asserted while any flag is set whose mask bit is on.

Suspend is found by timing continuous idle J: `CYCLES_PER_MS * SUSPEND_MS` consecutive clock cycles of J (three milliseconds by default) put the link into the suspended condition. A link state machine has three named states. LINK_ACTIVE is the state after reset and after any bus activity. LINK_IDLE means the line is in J and the idle timer is running. LINK_SUSPENDED means the idle limit was reached. Its transitions are:
- ACTIVE to IDLE when J is seen.
- IDLE to ACTIVE when any non-J state restarts the timer.
- ACTIVE or IDLE to SUSPENDED when the timer expires.
- SUSPENDED to ACTIVE on non-idle activity, which raises the wake-up flag.
- Any state to ACTIVE on end of bus reset, which raises no wake-up flag.

A second register holds the function-enable bit and the 7-bit device address that firmware assigns.

Top module: `usb_bus_event_irq`

## Requirements
- R1: After reset both registers read 0x00 and the interrupt output is low.
- R2: The address register (reg_sel = 0) holds the function-enable bit at bit 7 and the device address at bits 6:0. A write stores both fields, and a read returns them.
- R3: End of bus reset clears the device address to 0 and wins over a same-cycle address write. It leaves the function-enable bit unchanged.
- R4: The interrupt register (reg_sel = 1) holds wake-up at bit 5, end-of-reset at bit 4, start-of-frame at bit 3 and suspend at bit 0. Bits 7, 6, 2 and 1 always read 0 and ignore writes.
- R5: The suspend flag sets on the clock edge that samples the LIMIT-th consecutive cycle of idle J, where LIMIT = CYCLES_PER_MS*SUSPEND_MS. Any non-J sample restarts the count.
- R6: The wake-up flag sets only when the link is suspended and line_active is sampled high. line_active has no effect on it otherwise.
- R7: End of bus reset sets the end-of-reset flag and returns the link to ACTIVE without setting the wake-up flag.
- R8: A start-of-frame strobe sets the start-of-frame flag.
- R9: Writing 0 to a flag bit clears that flag and writing 1 leaves it unchanged. A hardware set in the same cycle as a software clear leaves the flag set.
- R10: irq is registered. One cycle after any flag is set while its mask bit is set, irq is high, and otherwise it is low. The mask bit order is irq_mask[3]=wake-up, [2]=end-of-reset, [1]=start-of-frame, [0]=suspend.
- R11: The suspend flag sets once per suspended episode. Continued idle J while suspended does not set it again after software clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-up reset |
| line_j_idle | input | 1 | Line is in idle J state this cycle |
| line_active | input | 1 | Non-idle activity on the line this cycle |
| bus_reset_end | input | 1 | Pulse: end of a USB bus reset detected |
| sof_seen | input | 1 | Pulse: valid start-of-frame packet received |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects address register, 1 selects interrupt register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| irq_mask | input | 4 | Per-flag interrupt enable |
| irq | output | 1 | Registered interrupt request |

## Verification
The main stimulus is a random line whose J, K-activity and SE0 levels persist for runs of random length. This lets idle stretches both reach and fall short of the suspend limit. Wake-up, bus-reset and start-of-frame events, register writes and mask changes are mixed in, so flag sets collide with software clears and with each other. Directed runs separate the exact suspend threshold (LIMIT-1 versus LIMIT cycles) from an interrupted run that restarts the timer. They also show that activity outside suspension raises no wake-up and that a long idle stretch does not set suspend a second time. Address checks separate a bus reset that wipes the address from one that would also drop the enable bit.

// File: rtl/usb_evt_pkg.sv
package usb_evt_pkg;

    typedef enum logic [1:0] {
        LINK_ACTIVE    = 2'd0,
        LINK_IDLE      = 2'd1,
        LINK_SUSPENDED = 2'd2
    } link_state_e;

    // positions inside the interrupt register; a driver decodes these
    localparam int BIT_WAKE = 5;
    localparam int BIT_EOR  = 4;
    localparam int BIT_SOF  = 3;
    localparam int BIT_SUSP = 0;

    typedef struct packed {
        logic wake;
        logic eor;
        logic sof;
        logic susp;
    } evt_flags_t;

endpackage

// File: rtl/usb_idle_timer.sv
module usb_idle_timer #(
    parameter int LIMIT = 36000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_j_idle,
    input  logic restart,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    // expired marks the LIMIT-th consecutive J sample
    assign expired = line_j_idle && (cnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (restart || !line_j_idle) begin
            cnt <= '0;
        end else if (cnt != LAST) begin
            cnt <= cnt + 1'b1;
        end
    end

    // R5
    cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);

    // R5
    restart_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !line_j_idle |=> cnt == '0);

endmodule

// File: rtl/usb_link_fsm.sv
module usb_link_fsm
    import usb_evt_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        line_j_idle,
    input  logic        line_active,
    input  logic        bus_reset_end,
    input  logic        expired,
    output link_state_e state,
    output logic        set_susp,
    output logic        set_wake
);
    link_state_e state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= LINK_ACTIVE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        if (bus_reset_end) begin
            state_nx = LINK_ACTIVE;
        end else begin
            unique case (state)
                LINK_ACTIVE: begin
                    if (expired)          state_nx = LINK_SUSPENDED;
                    else if (line_j_idle) state_nx = LINK_IDLE;
                end
                LINK_IDLE: begin
                    if (expired)           state_nx = LINK_SUSPENDED;
                    else if (!line_j_idle) state_nx = LINK_ACTIVE;
                end
                LINK_SUSPENDED: begin
                    if (line_active) state_nx = LINK_ACTIVE;
                end
                default: state_nx = LINK_ACTIVE;
            endcase
        end
    end

    // outputs: event pulses derived from state and transitions
    always_comb begin
        set_susp = (state_nx == LINK_SUSPENDED) && (state != LINK_SUSPENDED);
        set_wake = (state == LINK_SUSPENDED) && line_active;
    end

    // R6
    wake_only_suspended_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_active && state != LINK_SUSPENDED) |-> !set_wake);

    // R7
    reset_returns_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset_end |=> state == LINK_ACTIVE);

    // R11
    susp_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == LINK_SUSPENDED) |-> !set_susp);

endmodule

// File: rtl/usb_evt_flags.sv
module usb_evt_flags
    import usb_evt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  evt_flags_t hw_set,
    input  logic       sw_wr,
    input  logic [7:0] sw_wdata,
    input  logic [3:0] mask,
    output evt_flags_t flags,
    output logic       irq
);
    evt_flags_t keep;
    evt_flags_t flags_nx;

    always_comb begin
        keep = '1;
        if (sw_wr) begin
            keep.wake = sw_wdata[BIT_WAKE];
            keep.eor  = sw_wdata[BIT_EOR];
            keep.sof  = sw_wdata[BIT_SOF];
            keep.susp = sw_wdata[BIT_SUSP];
        end
        flags_nx = (flags & keep) | hw_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags <= '0;
            irq   <= 1'b0;
        end else begin
            flags <= flags_nx;
            irq   <= |(flags & mask);
        end
    end

    // R9
    set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hw_set.sof |=> flags.sof);

    // R10
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((flags & mask) == '0) |=> !irq);

    // R10
    irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((flags & mask) != '0) |=> irq);

endmodule

// File: rtl/usb_bus_event_irq.sv
module usb_bus_event_irq
    import usb_evt_pkg::*;
#(
    parameter int CYCLES_PER_MS = 12000,
    parameter int SUSPEND_MS    = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       line_j_idle,
    input  logic       line_active,
    input  logic       bus_reset_end,
    input  logic       sof_seen,
    input  logic       reg_wr,
    input  logic       reg_sel,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic [3:0] irq_mask,
    output logic       irq
);
    localparam int IDLE_LIMIT = CYCLES_PER_MS * SUSPEND_MS;
    localparam int ADDR_W     = 7;

    logic              expired;
    link_state_e       link_state;
    logic              set_susp;
    logic              set_wake;
    evt_flags_t        hw_set;
    evt_flags_t        flags;
    logic              func_en;
    logic [ADDR_W-1:0] dev_addr;
    logic              wr_addr;
    logic              wr_int;

    assign wr_addr = reg_wr && !reg_sel;
    assign wr_int  = reg_wr &&  reg_sel;

    usb_idle_timer #(.LIMIT(IDLE_LIMIT)) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .line_j_idle (line_j_idle),
        .restart     (bus_reset_end),
        .expired     (expired)
    );

    usb_link_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .line_j_idle   (line_j_idle),
        .line_active   (line_active),
        .bus_reset_end (bus_reset_end),
        .expired       (expired),
        .state         (link_state),
        .set_susp      (set_susp),
        .set_wake      (set_wake)
    );

    always_comb begin
        hw_set.wake = set_wake;
        hw_set.eor  = bus_reset_end;
        hw_set.sof  = sof_seen;
        hw_set.susp = set_susp;
    end

    usb_evt_flags u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .hw_set   (hw_set),
        .sw_wr    (wr_int),
        .sw_wdata (reg_wdata),
        .mask     (irq_mask),
        .flags    (flags),
        .irq      (irq)
    );

    // address register: enable cleared only by power-up reset
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            func_en  <= 1'b0;
            dev_addr <= '0;
        end else begin
            if (wr_addr) func_en <= reg_wdata[7];
            if (bus_reset_end) dev_addr <= '0;
            else if (wr_addr)  dev_addr <= reg_wdata[ADDR_W-1:0];
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_sel) begin
            reg_rdata[BIT_WAKE] = flags.wake;
            reg_rdata[BIT_EOR]  = flags.eor;
            reg_rdata[BIT_SOF]  = flags.sof;
            reg_rdata[BIT_SUSP] = flags.susp;
        end else begin
            reg_rdata = {func_en, dev_addr};
        end
    end

    // R3
    addr_wiped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset_end |=> dev_addr == '0);

    // R3
    enable_survives_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_reset_end && !wr_addr) |=> func_en == $past(func_en));

    // R4
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_sel |-> (reg_rdata[7:6] == 2'b00 && reg_rdata[2:1] == 2'b00));

    // R6
    wake_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags.wake) |-> $past(link_state) == LINK_SUSPENDED);

endmodule

// File: tb/usb_bus_event_irq_test.sv
module usb_bus_event_irq_test;
    localparam int CPM   = 4;
    localparam int SMS   = 3;
    localparam int LIMIT = CPM * SMS;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line_j_idle = 1'b0, line_active = 1'b0;
    logic       bus_reset_end = 1'b0, sof_seen = 1'b0;
    logic       reg_wr = 1'b0, reg_sel = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [3:0] irq_mask = '0;
    logic       irq;

    int tests = 0, fails = 0;
    bit finished = 0;

    // model state
    bit       m_susp, m_fen, m_irq;
    bit [6:0] m_addr;
    bit [3:0] m_flags; // {wake,eor,sof,susp}
    int       m_cnt;

    always #4 clk = ~clk;

    usb_bus_event_irq #(.CYCLES_PER_MS(CPM), .SUSPEND_MS(SMS)) uut (
        .clk(clk), .rst_n(rst_n), .line_j_idle(line_j_idle),
        .line_active(line_active), .bus_reset_end(bus_reset_end),
        .sof_seen(sof_seen), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_mask(irq_mask), .irq(irq)
    );

    function automatic bit [7:0] int_image(bit [3:0] f);
        return {2'b00, f[3], f[2], f[1], 2'b00, f[0]};
    endfunction

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic read_reg(bit sel, output logic [7:0] v);
        reg_sel = sel;
        #1;
        v = reg_rdata;
    endtask

    // advance the model one clock with the inputs currently driven
    task automatic model_step();
        bit done, wk, ss;
        bit [3:0] keep;
        done = line_j_idle && (m_cnt == LIMIT - 1);
        wk = m_susp && line_active;
        ss = !m_susp && done && !bus_reset_end;
        m_irq = |(m_flags & irq_mask);
        keep = 4'hF;
        if (reg_wr && reg_sel)
            keep = {reg_wdata[5], reg_wdata[4], reg_wdata[3], reg_wdata[0]};
        m_flags = (m_flags & keep) | {wk, bus_reset_end, sof_seen, ss};
        if (reg_wr && !reg_sel) m_fen = reg_wdata[7];
        if (bus_reset_end) m_addr = '0;
        else if (reg_wr && !reg_sel) m_addr = reg_wdata[6:0];
        if (bus_reset_end) m_susp = 0;
        else if (m_susp) m_susp = !line_active;
        else m_susp = done;
        if (bus_reset_end || !line_j_idle) m_cnt = 0;
        else if (m_cnt < LIMIT - 1) m_cnt++;
    endtask

    // drive inputs at a falling edge, clock once, compare at next falling edge
    task automatic step(bit j, bit act, bit rst_e, bit sof, bit wr, bit sel,
                        bit [7:0] wd, bit [3:0] mask);
        logic [7:0] v;
        line_j_idle = j; line_active = act; bus_reset_end = rst_e;
        sof_seen = sof; reg_wr = wr; reg_sel = sel; reg_wdata = wd;
        irq_mask = mask;
        model_step();
        @(posedge clk);
        @(negedge clk);
        reg_wr = 0; bus_reset_end = 0; sof_seen = 0;
        read_reg(1'b0, v);
        check("R2 addr reg", v, {m_fen, m_addr});
        read_reg(1'b1, v);
        check("R9 int reg", v, int_image(m_flags));
        check("R10 irq", {7'b0, irq}, {7'b0, m_irq});
    endtask

    task automatic clear_all(bit j);
        step(j, 0, 0, 0, 1, 1, 8'h00, 4'h0);
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            fails++;
            tests++;
            $display("FAIL watchdog actual=running expected=done");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        int line_kind;
        void'($urandom(32'h5EED_0042));
        m_susp = 0; m_fen = 0; m_irq = 0; m_addr = 0; m_flags = 0; m_cnt = 0;
        repeat (3) @(negedge clk);
        // R1 reset state
        read_reg(1'b0, v); check("R1 addr reset", v, 8'h00);
        read_reg(1'b1, v); check("R1 int reset", v, 8'h00);
        check("R1 irq reset", {7'b0, irq}, 8'h00);
        rst_n = 1;
        @(negedge clk);

        // R2 write address with enable
        step(0, 0, 0, 0, 1, 0, 8'hA5, 4'h0);
        read_reg(1'b0, v); check("R2 addr write", v, 8'hA5);
        // R3 bus reset clears address, keeps enable, beats same-cycle write
        step(0, 0, 1, 0, 1, 0, 8'hD3, 4'h0);
        read_reg(1'b0, v); check("R3 reset vs write", v, 8'h80);
        // R7 end-of-reset flag set
        read_reg(1'b1, v); check("R7 eor flag", v, 8'h10);
        // R4 reserved bits ignore writes of 1
        step(0, 0, 0, 0, 1, 1, 8'hFF, 4'h0);
        read_reg(1'b1, v); check("R4 reserved bits", v, 8'h10);
        clear_all(0);
        read_reg(1'b1, v); check("R9 clear by zero", v, 8'h00);

        // R5 exact threshold
        for (int i = 0; i < LIMIT - 1; i++) step(1, 0, 0, 0, 0, 0, 0, 4'h0);
        read_reg(1'b1, v); check("R5 one short", v, 8'h00);
        step(1, 0, 0, 0, 0, 0, 0, 4'h1);
        read_reg(1'b1, v); check("R5 suspend set", v, 8'h01);
        step(1, 0, 0, 0, 0, 0, 0, 4'h1);
        check("R10 irq on suspend", {7'b0, irq}, 8'h01);
        // R11 stays idle, cleared, no retrigger
        clear_all(1);
        for (int i = 0; i < 2 * LIMIT; i++) step(1, 0, 0, 0, 0, 0, 0, 4'h0);
        read_reg(1'b1, v); check("R11 no retrigger", v, 8'h00);
        // R6 wake from suspension
        step(0, 1, 0, 0, 0, 0, 0, 4'h0);
        read_reg(1'b1, v); check("R6 wake set", v, 8'h20);
        clear_all(0);
        step(0, 1, 0, 0, 0, 0, 0, 4'h0);
        read_reg(1'b1, v); check("R6 no wake when active", v, 8'h00);
        // R5 restart by SE0
        for (int i = 0; i < LIMIT - 1; i++) step(1, 0, 0, 0, 0, 0, 0, 4'h0);
        step(0, 0, 0, 0, 0, 0, 0, 4'h0);
        for (int i = 0; i < LIMIT - 1; i++) step(1, 0, 0, 0, 0, 0, 0, 4'h0);
        read_reg(1'b1, v); check("R5 restart", v, 8'h00);
        // R7 bus reset leaves suspension without wake
        step(1, 0, 0, 0, 0, 0, 0, 4'h0);
        step(0, 0, 1, 0, 0, 0, 0, 4'h0);
        step(0, 1, 0, 0, 0, 0, 0, 4'h0);
        read_reg(1'b1, v); check("R7 no wake after reset", v, 8'h11);
        // R8 + R9 set wins over clear
        step(0, 0, 0, 1, 1, 1, 8'h00, 4'h2);
        read_reg(1'b1, v); check("R8 sof set beats clear", v, 8'h08);
        clear_all(0);

        // constrained random
        line_kind = 0;
        for (int n = 0; n < 4000; n++) begin
            if ($urandom_range(0, 99) < 12) line_kind = $urandom_range(0, 2);
            if (n % 600 < 300 && $urandom_range(0, 99) < 8) line_kind = 0;
            step(line_kind == 0, line_kind == 1,
                 $urandom_range(0, 99) < 2, $urandom_range(0, 99) < 5,
                 $urandom_range(0, 99) < 10, 1'($urandom_range(0, 1)),
                 8'($urandom), 4'($urandom));
        end

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule